// File: doc/BRIEF.md
# Over-Temperature Alarm with Hysteresis

This block watches a temperature sensor's conversion results and raises an alarm when the die gets too hot. Each time the converter signals that a result is ready, the block compares the signed 16-bit value with a programmable upper threshold and a programmable lower threshold. The alarm turns on above the upper threshold. It stays on until a result drops under the lower threshold, so the pair of thresholds forms a hysteresis band. Software can also cancel the alarm by writing a clear bit.

The alarm drives a pin model made of two signals: a logic level and a drive-low enable for an external open-drain pad. A polarity bit sets the pin's active level, and a disable bit masks the pin and the alarm status bit. Two sticky flags record that the upper threshold was exceeded or that the lower threshold was undercut. Each flag stays set until two things have happened, in either order: a later result has left that condition, and the control/status word has been read. Both thresholds and the control/status word can be read back.

Top module: `thermal_alarm`

## Requirements
- R1: After reset, the upper threshold reads 4880h, the lower threshold reads 4600h, polarity and disable are 0, the alarm is inactive with pin_level high and pin_drive_low low, and both sticky flags are 0.
- R2: On a conversion strobe whose result, taken as signed two's complement, is strictly greater than the upper threshold, the alarm becomes active one clock later. A result equal to the threshold does not set it.
- R3: The alarm clears only on a conversion strobe whose signed result is strictly less than the lower threshold. Results between the thresholds, results equal to the lower threshold, and cycles with no strobe leave the alarm unchanged.
- R4: A control write with bit 13 set clears the alarm. The next strobe whose result is above the upper threshold sets it again. Bit 13 always reads back as 0.
- R5: A control write with bit 13 clear does not clear the alarm, even when bits 15 and 14 (the shutdown and one-shot requests) are set.
- R6: Control bit 6 selects the polarity. With bit 6 at 1, pin_level equals the alarm. With bit 6 at 0, pin_level is the inverse of the alarm. While the pin is enabled, pin_drive_low is always the inverse of pin_level.
- R7: While control bit 7 is 1, the status bit (readback bit 11) is 0, pin_level is 1 and pin_drive_low is 0. The internal alarm state is still kept, and it appears again when bit 7 returns to 0.
- R8: The high flag (readback bit 10) sets on a result above the upper threshold. It clears only after both of these have happened since its last setting, in either order: a result not above the threshold has arrived, and the status word has been read.
- R9: The low flag (readback bit 9) sets on a result below the lower threshold. It clears under the same two-event rule, where the recovery event is a result not below the threshold.
- R10: Each threshold register stores only bits 15:5 of the written value. Bits 4:0 read back as 0, and comparisons use the stored value.
- R11: The control/status readback holds the status in bit 11, the high flag in bit 10, the low flag in bit 9, disable in bit 7 and polarity in bit 6. Every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle strobe marking a new conversion result |
| conv_result | input | 16 | Signed conversion result |
| wr_hi | input | 1 | Write strobe for the upper threshold |
| wr_lo | input | 1 | Write strobe for the lower threshold |
| wr_ctl | input | 1 | Write strobe for the control bits |
| wr_data | input | 16 | Write data shared by all write strobes |
| stat_rd | input | 1 | Strobe marking a read of the control/status word |
| pin_level | output | 1 | Logic level of the alarm pin |
| pin_drive_low | output | 1 | Enable for pulling the pad low |
| alarm_stat | output | 1 | Alarm status (masked by disable) |
| hi_flag | output | 1 | Sticky flag: upper threshold exceeded |
| lo_flag | output | 1 | Sticky flag: below the lower threshold |
| hi_limit_rd | output | 16 | Upper threshold readback |
| lo_limit_rd | output | 16 | Lower threshold readback |
| ctl_rd | output | 16 | Control/status readback |

## Verification
The hardest situation to reach is a sticky flag that must survive one of its two clearing events and then clear on the other. Both orders must be covered: a status read while the temperature is still hot followed by a recovering result, and a recovering result followed by a read. The stimulus ramps the result up and down through each hysteresis band, for every polarity and disable setting and for normal, negative and equal threshold pairs. It inserts status reads at intervals that do not line up with the ramp, so both orders occur many times. Directed sequences then target exact threshold equality, the clear bit while the result is still hot, and writes that set bits 15 and 14 without bit 13.

// File: rtl/thermal_alarm.sv
module thermal_alarm #(
  parameter int W = 16,
  parameter int LSB_DROP = 5,
  parameter logic [W-1:0] HI_RESET = 16'h4880,
  parameter logic [W-1:0] LO_RESET = 16'h4600
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         conv_done,
  input  logic [W-1:0] conv_result,
  input  logic         wr_hi,
  input  logic         wr_lo,
  input  logic         wr_ctl,
  input  logic [W-1:0] wr_data,
  input  logic         stat_rd,
  output logic         pin_level,
  output logic         pin_drive_low,
  output logic         alarm_stat,
  output logic         hi_flag,
  output logic         lo_flag,
  output logic [W-1:0] hi_limit_rd,
  output logic [W-1:0] lo_limit_rd,
  output logic [W-1:0] ctl_rd
);
  localparam int LW     = W - LSB_DROP;
  localparam int B_CLR  = 13;
  localparam int B_STAT = 11;
  localparam int B_HF   = 10;
  localparam int B_LF   = 9;
  localparam int B_DIS  = 7;
  localparam int B_POL  = 6;

  logic [LW-1:0] hi_q, lo_q;
  logic pol_q, dis_q, alm_q;
  logic hseen_q, lseen_q, hnow_q, lnow_q;
  logic signed [W-1:0] res_s, hi_s, lo_s;
  logic above, below, clr_req;

  assign res_s   = conv_result;
  assign hi_s    = {hi_q, {LSB_DROP{1'b0}}};
  assign lo_s    = {lo_q, {LSB_DROP{1'b0}}};
  assign above   = conv_done && (res_s > hi_s);
  assign below   = conv_done && (res_s < lo_s);
  assign clr_req = wr_ctl && wr_data[B_CLR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= HI_RESET[W-1:LSB_DROP];
      lo_q <= LO_RESET[W-1:LSB_DROP];
    end else begin
      if (wr_hi) hi_q <= wr_data[W-1:LSB_DROP];
      if (wr_lo) lo_q <= wr_data[W-1:LSB_DROP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= 1'b0;
      dis_q <= 1'b0;
    end else if (wr_ctl) begin
      pol_q <= wr_data[B_POL];
      dis_q <= wr_data[B_DIS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       alm_q <= 1'b0;
    else if (above)   alm_q <= 1'b1;
    else if (below)   alm_q <= 1'b0;
    else if (clr_req) alm_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_flag <= 1'b0;
      hseen_q <= 1'b0;
      hnow_q  <= 1'b0;
    end else if (conv_done) begin
      hnow_q <= above;
      if (above) begin
        hi_flag <= 1'b1;
        hseen_q <= 1'b0;
      end else if (hseen_q || (stat_rd && hi_flag)) begin
        hi_flag <= 1'b0;
        hseen_q <= 1'b0;
      end
    end else if (stat_rd && hi_flag) begin
      if (hnow_q) hseen_q <= 1'b1;
      else        hi_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_flag <= 1'b0;
      lseen_q <= 1'b0;
      lnow_q  <= 1'b0;
    end else if (conv_done) begin
      lnow_q <= below;
      if (below) begin
        lo_flag <= 1'b1;
        lseen_q <= 1'b0;
      end else if (lseen_q || (stat_rd && lo_flag)) begin
        lo_flag <= 1'b0;
        lseen_q <= 1'b0;
      end
    end else if (stat_rd && lo_flag) begin
      if (lnow_q) lseen_q <= 1'b1;
      else        lo_flag <= 1'b0;
    end
  end

  assign alarm_stat    = alm_q & ~dis_q;
  assign pin_level     = dis_q ? 1'b1 : (pol_q ? alarm_stat : ~alarm_stat);
  assign pin_drive_low = ~pin_level;
  assign hi_limit_rd   = hi_s;
  assign lo_limit_rd   = lo_s;

  always_comb begin
    ctl_rd         = '0;
    ctl_rd[B_STAT] = alarm_stat;
    ctl_rd[B_HF]   = hi_flag;
    ctl_rd[B_LF]   = lo_flag;
    ctl_rd[B_DIS]  = dis_q;
    ctl_rd[B_POL]  = pol_q;
  end

  // R2
  alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    above |=> alm_q);
  // R3
  alarm_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (below && !above) |=> !alm_q);
  // R3
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !clr_req) |=> $stable(alm_q));
  // R4
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !conv_done) |=> !alm_q);
  // R7
  disable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> (!alarm_stat && pin_level && !pin_drive_low));
  // R8
  hflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    above |=> hi_flag);
  // R8
  hflag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_flag && !conv_done && (!stat_rd || hnow_q)) |=> hi_flag);
  // R9
  lflag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    below |=> lo_flag);
  // R9
  lflag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_flag && !conv_done && (!stat_rd || lnow_q)) |=> lo_flag);
endmodule

// File: tb/thermal_alarm_test.sv
`timescale 1ns/1ps
module thermal_alarm_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_done = 1'b0;
  logic [15:0] conv_result = '0;
  logic wr_hi = 1'b0, wr_lo = 1'b0, wr_ctl = 1'b0;
  logic [15:0] wr_data = '0;
  logic stat_rd = 1'b0;
  logic pin_level, pin_drive_low, alarm_stat, hi_flag, lo_flag;
  logic [15:0] hi_limit_rd, lo_limit_rd, ctl_rd;

  int checks = 0;
  int failures = 0;

  logic signed [15:0] m_hi = 16'sh4880, m_lo = 16'sh4600;
  logic m_pol = 0, m_dis = 0, m_alm = 0;
  logic m_hf = 0, m_lf = 0, m_hseen = 0, m_lseen = 0, m_hnow = 0, m_lnow = 0;

  always #4 clk = ~clk;

  thermal_alarm uut (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_result(conv_result),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .stat_rd(stat_rd), .pin_level(pin_level), .pin_drive_low(pin_drive_low),
    .alarm_stat(alarm_stat), .hi_flag(hi_flag), .lo_flag(lo_flag),
    .hi_limit_rd(hi_limit_rd), .lo_limit_rd(lo_limit_rd), .ctl_rd(ctl_rd));

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic verify(string req);
    logic st, lvl;
    logic [15:0] c;
    st  = m_alm & ~m_dis;
    lvl = m_dis ? 1'b1 : (m_pol ? st : ~st);
    c = '0;
    c[11] = st; c[10] = m_hf; c[9] = m_lf; c[7] = m_dis; c[6] = m_pol;
    chk(req, "alarm_stat", {15'b0, alarm_stat}, {15'b0, st});
    chk("R6", "pin_level", {15'b0, pin_level}, {15'b0, lvl});
    chk("R6", "pin_drive_low", {15'b0, pin_drive_low}, {15'b0, ~lvl});
    chk("R8", "hi_flag", {15'b0, hi_flag}, {15'b0, m_hf});
    chk("R9", "lo_flag", {15'b0, lo_flag}, {15'b0, m_lf});
    chk("R11", "ctl_rd", ctl_rd, c);
    chk("R10", "hi_limit_rd", hi_limit_rd, m_hi);
    chk("R10", "lo_limit_rd", lo_limit_rd, m_lo);
  endtask

  task automatic conv(logic signed [15:0] v, string req);
    logic a, b;
    @(negedge clk); conv_done = 1; conv_result = v;
    @(negedge clk); conv_done = 0;
    a = v > m_hi; b = v < m_lo;
    if (a) m_alm = 1; else if (b) m_alm = 0;
    m_hnow = a;
    if (a) begin m_hf = 1; m_hseen = 0; end
    else if (m_hseen) begin m_hf = 0; m_hseen = 0; end
    m_lnow = b;
    if (b) begin m_lf = 1; m_lseen = 0; end
    else if (m_lseen) begin m_lf = 0; m_lseen = 0; end
    verify(req);
  endtask

  task automatic rd(string req);
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
    if (m_hf) begin if (m_hnow) m_hseen = 1; else m_hf = 0; end
    if (m_lf) begin if (m_lnow) m_lseen = 1; else m_lf = 0; end
    verify(req);
  endtask

  task automatic wctl(logic [15:0] d, string req);
    @(negedge clk); wr_ctl = 1; wr_data = d;
    @(negedge clk); wr_ctl = 0;
    m_pol = d[6]; m_dis = d[7];
    if (d[13]) m_alm = 0;
    verify(req);
  endtask

  task automatic wlim(logic [15:0] hi, logic [15:0] lo);
    @(negedge clk); wr_hi = 1; wr_lo = 1; wr_data = hi;
    @(negedge clk); wr_lo = 0; wr_data = lo; wr_hi = 0; wr_lo = 1;
    @(negedge clk); wr_lo = 0;
    m_hi = {hi[15:5], 5'b0};
    m_lo = {lo[15:5], 5'b0};
    verify("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] his [3];
    logic [15:0] los [3];
    int n;
    his[0] = 16'h4880; los[0] = 16'h4600;
    his[1] = 16'h0040; los[1] = 16'hFFC0;
    his[2] = 16'h0100; los[2] = 16'h0100;
    repeat (3) @(negedge clk);
    // R1: reset state
    verify("R1");
    rst_n = 1;
    @(negedge clk);
    verify("R1");
    n = 0;
    for (int cfg = 0; cfg < 4; cfg++) begin
      wctl({2'b00, 1'b1, 5'b0, cfg[1], cfg[0], 6'b0}, "R4");
      for (int p = 0; p < 3; p++) begin
        wlim(his[p], los[p]);
        for (int k = 0; k <= 60; k++) begin
          conv(16'($signed(los[p]) - 160 + 16 * k), "R2");
          n++;
          if (n % 5 == 0) rd("R8");
        end
        for (int k = 60; k >= 0; k--) begin
          conv(16'($signed(los[p]) - 160 + 16 * k), "R3");
          n++;
          if (n % 7 == 0) rd("R9");
        end
        conv(his[p], "R2");
        conv(his[p] + 16'd1, "R2");
        conv(los[p], "R3");
        conv(los[p] - 16'd1, "R3");
        rd("R9");
      end
    end
    // R10: low bits dropped, stored value used in compares
    wctl(16'h2000, "R4");
    wlim(16'h12FF, 16'h101F);
    conv(16'h12E0, "R10");
    conv(16'h12E1, "R10");
    conv(16'h1000, "R10");
    conv(16'h0FFF, "R10");
    // R4: clear while hot, then re-arm
    conv(16'h2000, "R2");
    wctl(16'h2000, "R4");
    conv(16'h1100, "R4");
    conv(16'h2000, "R4");
    // R5: shutdown and one-shot requests keep the alarm
    wctl(16'hC000, "R5");
    wctl(16'h4000, "R5");
    conv(16'h1100, "R5");
    // R7: disable masks the pin; state persists
    wctl(16'h0080, "R7");
    conv(16'h2000, "R7");
    wctl(16'h00C0, "R7");
    wctl(16'h0040, "R7");
    wctl(16'h0000, "R7");
    // R8: hot read then recovery
    conv(16'h2000, "R8");
    rd("R8");
    conv(16'h1100, "R8");
    // R8: recovery then read
    conv(16'h2000, "R8");
    conv(16'h1100, "R8");
    conv(16'h1100, "R8");
    rd("R8");
    // R9: same two orders on the low side
    conv(16'h0F00, "R9");
    rd("R9");
    conv(16'h1100, "R9");
    conv(16'h0F00, "R9");
    conv(16'h1100, "R9");
    rd("R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule